// File: doc/BRIEF.md
# Four-Page Cluster Translation Cache

This block is a small, fully associative cache of address translations. Each entry covers an aligned group of four consecutive virtual pages. It holds one tag, one base frame number and a four-bit residency mask. The four physical frames of a group are contiguous and aligned, so page k of the group translates to base + k. A page translates only while its mask bit is set.

A lookup is answered combinationally in the cycle it is presented. A page-table walker installs groups through a fill port. A fill either merges into a resident entry, replaces one, or takes a new slot. A free slot is preferred, and round-robin eviction is used when no slot is free. An invalidate port removes one page or a whole group.

The fill port is a valid/ready stream. A fill transfers on a clock edge where `fill_valid` and `fill_ready` are both high. `fill_ready` drops in any cycle where an invalidate is presented. The walker must then hold its fill stable until it is accepted. Lookup and invalidate are plain control inputs with no handshake.

Top module: `ps_tlb`

## Requirements
- R1: After reset no lookup hits, and `lk_ppn` reads zero.
- R2: `lk_hit` is high in the same cycle exactly when a resident entry's tag equals `lk_vpn[VPN_W-1:2]` and that entry's mask bit number `lk_vpn[1:0]` is 1. On a miss `lk_ppn` is zero.
- R3: On a hit, `lk_ppn` equals the entry's base in bits `[PPN_W-1:2]` with `lk_vpn[1:0]` in bits `[1:0]`. The result of an accepted fill is visible to lookups from the next cycle.
- R4: A fill whose tag and base both equal a resident entry's tag and base ORs `fill_mask` into that entry's mask. No other entry changes.
- R5: A fill whose tag matches a resident entry but whose base differs replaces that entry's base, and replaces its mask with `fill_mask`.
- R6: A fill with a new tag goes to the lowest-numbered empty entry (mask all zero) whenever one exists. It leaves the eviction pointer unchanged.
- R7: When all 8 entries are occupied, a fill with a new tag replaces the entry selected by the eviction pointer. The pointer starts at 0 after reset and then advances by one, wrapping modulo 8.
- R8: An accepted fill with `fill_mask` equal to zero changes nothing.
- R9: An invalidate with `inv_all` low clears mask bit `inv_vpn[1:0]` of the entry whose tag matches `inv_vpn[VPN_W-1:2]`. An entry whose mask reaches zero is empty and can be reused.
- R10: An invalidate with `inv_all` high clears the whole mask of the matching entry. An invalidate that matches no entry changes nothing.
- R11: `fill_ready` is the inverse of `inv_valid`, so the invalidate wins and the fill waits. A lookup always sees the contents from before the update made on the same clock edge.
- R12: No two resident entries ever share a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Translation found and resident |
| lk_ppn | output | PPN_W | Translated physical page number, zero on a miss |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_tag | input | VPN_W-2 | Group tag (virtual page number without the two low bits) |
| fill_base | input | PPN_W-2 | Aligned base frame (physical page number without the two low bits) |
| fill_mask | input | 4 | Resident pages of the group, bit k for page k |
| inv_valid | input | 1 | Invalidate request |
| inv_all | input | 1 | Invalidate the whole group instead of one page |
| inv_vpn | input | VPN_W | Page (or any page of the group) to invalidate |

## Verification
Four properties are checked on every cycle:
- tags stay unique across the lookup match;
- a hit is backed by exactly one entry;
- a miss drives a zero frame number;
- after an accepted fill or an invalidate, an unchanged lookup address reflects that update on the next cycle.

Some behaviours only show up over a whole scenario:
- the choice between merge and replace;
- the preference for an empty slot;
- the exact order of round-robin eviction;
- fills that are ignored.

The bench shows these with directed sequences. It then runs a long random mix of fills and invalidates over a small tag pool, compared against a reference model.

// File: rtl/ps_tlb_pkg.sv
package ps_tlb_pkg;
  parameter int unsigned DEF_VPN_W   = 52;
  parameter int unsigned DEF_PPN_W   = 40;
  parameter int unsigned DEF_ENTRIES = 8;
  parameter int unsigned SUB_PAGES   = 4;
  localparam int unsigned SUB_BITS   = $clog2(SUB_PAGES);

  typedef enum logic [2:0] {
    UPD_NONE,
    UPD_CLEAR,
    UPD_DROP,
    UPD_MERGE,
    UPD_REPLACE,
    UPD_ALLOC
  } upd_e;
endpackage

// File: rtl/ps_tlb_match.sv
module ps_tlb_match #(
  parameter int unsigned TAG_W   = 50,
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned SUB     = 4,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [TAG_W-1:0]              key,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [ENTRIES-1:0][SUB-1:0]   masks,
  output logic [ENTRIES-1:0]            tag_hit,
  output logic [IDX_W-1:0]              idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign tag_hit[g] = (|masks[g]) && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tag_hit[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ps_tlb_victim.sv
module ps_tlb_victim #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned SUB     = 4,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ENTRIES-1:0][SUB-1:0] masks,
  input  logic                        alloc,
  output logic [IDX_W-1:0]            vidx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] first_free;
  logic             have_free;

  always_comb begin
    have_free  = 1'b0;
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (masks[i] == '0) begin
        have_free  = 1'b1;
        first_free = IDX_W'(i);
      end
    end
    vidx = have_free ? first_free : rr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (alloc && !have_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/ps_tlb.sv
module ps_tlb
  import ps_tlb_pkg::*;
#(
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned PPN_W   = DEF_PPN_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [VPN_W-1:0]          lk_vpn,
  output logic                      lk_hit,
  output logic [PPN_W-1:0]          lk_ppn,
  input  logic                      fill_valid,
  output logic                      fill_ready,
  input  logic [VPN_W-SUB_BITS-1:0] fill_tag,
  input  logic [PPN_W-SUB_BITS-1:0] fill_base,
  input  logic [SUB_PAGES-1:0]      fill_mask,
  input  logic                      inv_valid,
  input  logic                      inv_all,
  input  logic [VPN_W-1:0]          inv_vpn
);
  localparam int unsigned SB     = SUB_BITS;
  localparam int unsigned TAG_W  = VPN_W - SB;
  localparam int unsigned BASE_W = PPN_W - SB;
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][TAG_W-1:0]     tag_q;
  logic [ENTRIES-1:0][BASE_W-1:0]    base_q;
  logic [ENTRIES-1:0][SUB_PAGES-1:0] mask_q;

  logic [ENTRIES-1:0] lk_tag_hit, lk_page_hit, f_tag_hit, i_tag_hit;
  logic [IDX_W-1:0]   lk_idx, f_idx, i_idx, v_idx;
  logic               fill_fire, same_base, f_any, i_any;
  upd_e               op;

  ps_tlb_match #(.TAG_W(TAG_W), .ENTRIES(ENTRIES), .SUB(SUB_PAGES)) u_lk_match (
    .key(lk_vpn[VPN_W-1:SB]), .tags(tag_q), .masks(mask_q),
    .tag_hit(lk_tag_hit), .idx(lk_idx)
  );

  ps_tlb_match #(.TAG_W(TAG_W), .ENTRIES(ENTRIES), .SUB(SUB_PAGES)) u_fill_match (
    .key(fill_tag), .tags(tag_q), .masks(mask_q),
    .tag_hit(f_tag_hit), .idx(f_idx)
  );

  ps_tlb_match #(.TAG_W(TAG_W), .ENTRIES(ENTRIES), .SUB(SUB_PAGES)) u_inv_match (
    .key(inv_vpn[VPN_W-1:SB]), .tags(tag_q), .masks(mask_q),
    .tag_hit(i_tag_hit), .idx(i_idx)
  );

  ps_tlb_victim #(.ENTRIES(ENTRIES), .SUB(SUB_PAGES)) u_victim (
    .clk(clk), .rst_n(rst_n), .masks(mask_q),
    .alloc(op == UPD_ALLOC), .vidx(v_idx)
  );

  // lookup path: tag match qualified by the page's residency bit
  for (genvar g = 0; g < ENTRIES; g++) begin : g_page
    assign lk_page_hit[g] = lk_tag_hit[g] & mask_q[g][lk_vpn[SB-1:0]];
  end

  assign lk_hit = |lk_page_hit;
  assign lk_ppn = lk_hit ? {base_q[lk_idx], lk_vpn[SB-1:0]} : '0;

  // update selection: invalidate has priority over fill
  assign fill_ready = !inv_valid;
  assign fill_fire  = fill_valid && fill_ready && (fill_mask != '0);
  assign f_any      = |f_tag_hit;
  assign i_any      = |i_tag_hit;
  assign same_base  = (base_q[f_idx] == fill_base);

  always_comb begin
    op = UPD_NONE;
    if (inv_valid) begin
      if (i_any) op = inv_all ? UPD_DROP : UPD_CLEAR;
    end else if (fill_fire) begin
      if (!f_any)         op = UPD_ALLOC;
      else if (same_base) op = UPD_MERGE;
      else                op = UPD_REPLACE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else begin
      unique case (op)
        UPD_CLEAR:   mask_q[i_idx][inv_vpn[SB-1:0]] <= 1'b0;
        UPD_DROP:    mask_q[i_idx] <= '0;
        UPD_MERGE:   mask_q[f_idx] <= mask_q[f_idx] | fill_mask;
        UPD_REPLACE: begin
          base_q[f_idx] <= fill_base;
          mask_q[f_idx] <= fill_mask;
        end
        UPD_ALLOC: begin
          tag_q[v_idx]  <= fill_tag;
          base_q[v_idx] <= fill_base;
          mask_q[v_idx] <= fill_mask;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ps_tlb_chk.sv
module ps_tlb_chk
  import ps_tlb_pkg::*;
#(
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned PPN_W   = DEF_PPN_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [VPN_W-1:0]          lk_vpn,
  input logic                      lk_hit,
  input logic [PPN_W-1:0]          lk_ppn,
  input logic                      fill_valid,
  input logic                      fill_ready,
  input logic [VPN_W-SUB_BITS-1:0] fill_tag,
  input logic [PPN_W-SUB_BITS-1:0] fill_base,
  input logic [SUB_PAGES-1:0]      fill_mask,
  input logic                      inv_valid,
  input logic                      inv_all,
  input logic [VPN_W-1:0]          inv_vpn,
  input logic [ENTRIES-1:0]        lk_tag_hit,
  input logic [ENTRIES-1:0]        lk_page_hit
);
  localparam int unsigned SB = SUB_BITS;

  AST_ONE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_tag_hit)); // R12

  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($countones(lk_page_hit) == 1)); // R2

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0)); // R2

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && fill_tag == lk_vpn[VPN_W-1:SB] && fill_mask[lk_vpn[SB-1:0]])
    |=> (!$stable(lk_vpn) || (lk_hit && lk_ppn[PPN_W-1:SB] == $past(fill_base)))); // R3

  AST_INV_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_all && inv_vpn == lk_vpn)
    |=> (!$stable(lk_vpn) || !lk_hit)); // R9

  AST_INV_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_all && inv_vpn[VPN_W-1:SB] == lk_vpn[VPN_W-1:SB])
    |=> (!$stable(lk_vpn) || !lk_hit)); // R10
endmodule

bind ps_tlb ps_tlb_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
  .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_tag(fill_tag),
  .fill_base(fill_base), .fill_mask(fill_mask), .inv_valid(inv_valid),
  .inv_all(inv_all), .inv_vpn(inv_vpn), .lk_tag_hit(lk_tag_hit),
  .lk_page_hit(lk_page_hit)
);

// File: tb/ps_tlb_test.sv
module ps_tlb_test;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 52;
  localparam int PW = 40;
  localparam int TW = VW - 2;
  localparam int BW = PW - 2;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic          lk_hit;
  logic [PW-1:0] lk_ppn;
  logic          fill_valid = 1'b0;
  logic          fill_ready;
  logic [TW-1:0] fill_tag = '0;
  logic [BW-1:0] fill_base = '0;
  logic [3:0]    fill_mask = '0;
  logic          inv_valid = 1'b0;
  logic          inv_all = 1'b0;
  logic [VW-1:0] inv_vpn = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  ps_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_tag(fill_tag),
    .fill_base(fill_base), .fill_mask(fill_mask), .inv_valid(inv_valid),
    .inv_all(inv_all), .inv_vpn(inv_vpn)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model
  logic [TW-1:0] m_tag [NE];
  logic [BW-1:0] m_base[NE];
  logic [3:0]    m_mask[NE];
  int            m_rr;

  function automatic logic [TW-1:0] tg(int k);
    return {25'(k * 3 + 5), 25'(k)};
  endfunction

  function automatic logic [BW-1:0] bs(int k);
    return BW'(k * 7 + 1) << 4;
  endfunction

  function automatic logic [VW-1:0] va(int k, int s);
    return {tg(k), 2'(s)};
  endfunction

  function automatic int m_find(logic [TW-1:0] t);
    for (int i = 0; i < NE; i++) if (m_mask[i] != 0 && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic void m_update();
    int k;
    int fr;
    if (inv_valid) begin
      k = m_find(inv_vpn[VW-1:2]);
      if (k >= 0) begin
        if (inv_all) m_mask[k] = 4'b0;
        else m_mask[k][inv_vpn[1:0]] = 1'b0;
      end
    end else if (fill_valid && fill_mask != 0) begin
      k = m_find(fill_tag);
      if (k >= 0) begin
        if (m_base[k] == fill_base) m_mask[k] = m_mask[k] | fill_mask;
        else begin m_base[k] = fill_base; m_mask[k] = fill_mask; end
      end else begin
        fr = -1;
        for (int i = NE - 1; i >= 0; i--) if (m_mask[i] == 0) fr = i;
        if (fr < 0) begin fr = m_rr; m_rr = (m_rr + 1) % NE; end
        m_tag[fr] = fill_tag; m_base[fr] = fill_base; m_mask[fr] = fill_mask;
      end
    end
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    fill_valid = 1'b0; fill_mask = '0; inv_valid = 1'b0; inv_all = 1'b0;
  endtask

  // inputs are set by the caller just after a negedge
  task automatic step(bit cmp);
    int k;
    logic eh;
    logic [PW-1:0] ep;
    #1;
    if (cmp) begin
      k = m_find(lk_vpn[VW-1:2]);
      eh = (k >= 0) && m_mask[k][lk_vpn[1:0]];
      ep = eh ? {m_base[k], lk_vpn[1:0]} : '0;
      chk("R2 hit", 64'(lk_hit), 64'(eh));
      chk("R3 ppn", 64'(lk_ppn), 64'(ep));
      chk("R11 ready", 64'(fill_ready), 64'(!inv_valid));
    end
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic look(logic [VW-1:0] v, logic eh, logic [PW-1:0] ep, string req);
    idle();
    lk_vpn = v;
    #1;
    chk(req, 64'(lk_hit), 64'(eh));
    chk(req, 64'(lk_ppn), 64'(ep));
    step(1'b0);
  endtask

  task automatic fill(int t, int b, logic [3:0] m);
    idle();
    fill_valid = 1'b1; fill_tag = tg(t); fill_base = bs(b); fill_mask = m;
    step(1'b0);
  endtask

  task automatic inval(logic [VW-1:0] v, logic all);
    idle();
    inv_valid = 1'b1; inv_all = all; inv_vpn = v;
    step(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NE; i++) begin m_tag[i] = '0; m_base[i] = '0; m_mask[i] = '0; end
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    look(va(0, 0), 1'b0, '0, "R1 empty after reset");
    look(va(5, 3), 1'b0, '0, "R1 empty after reset");

    // R11: lookup during the fill cycle sees the old contents
    idle();
    fill_valid = 1'b1; fill_tag = tg(0); fill_base = bs(0); fill_mask = 4'b0001;
    lk_vpn = va(0, 0);
    #1;
    chk("R11 pre-update lookup", 64'(lk_hit), 64'(0));
    step(1'b0);
    look(va(0, 0), 1'b1, {bs(0), 2'd0}, "R3 base plus page");
    look(va(0, 1), 1'b0, '0, "R2 mask bit clear");

    fill(0, 0, 4'b0100); // R4 merge
    look(va(0, 2), 1'b1, {bs(0), 2'd2}, "R4 merged page");
    look(va(0, 0), 1'b1, {bs(0), 2'd0}, "R4 old page kept");

    fill(0, 1, 4'b0010); // R5 replace
    look(va(0, 0), 1'b0, '0, "R5 old mask replaced");
    look(va(0, 1), 1'b1, {bs(1), 2'd1}, "R5 new base");

    fill(1, 0, 4'b0000); // R8 empty mask
    look(va(1, 0), 1'b0, '0, "R8 zero mask ignored");

    inval(va(0, 1), 1'b0);
    look(va(0, 1), 1'b0, '0, "R9 page cleared");

    for (int k = 0; k < NE; k++) fill(k, k % 4, 4'b1111);
    look(va(7, 3), 1'b1, {bs(3), 2'd3}, "R6 fills into empty slots");

    fill(8, 0, 4'b1111); // evicts slot 0
    look(va(0, 0), 1'b0, '0, "R7 pointer slot 0 evicted");
    look(va(8, 1), 1'b1, {bs(0), 2'd1}, "R7 new group resident");
    fill(9, 1, 4'b1111); // evicts slot 1
    look(va(1, 2), 1'b0, '0, "R7 pointer slot 1 evicted");
    look(va(2, 2), 1'b1, {bs(2), 2'd2}, "R7 slot 2 untouched");

    inval(va(3, 2), 1'b1);
    look(va(3, 0), 1'b0, '0, "R10 whole group cleared");
    inval(va(20, 0), 1'b1);
    look(va(4, 0), 1'b1, {bs(0), 2'd0}, "R10 miss invalidate harmless");
    fill(10, 2, 4'b1111); // goes to freed slot 3
    look(va(10, 0), 1'b1, {bs(2), 2'd0}, "R6 free slot reused");
    fill(11, 3, 4'b1111); // pointer still at 2
    look(va(2, 0), 1'b0, '0, "R7 pointer unchanged by free use");
    look(va(10, 1), 1'b1, {bs(2), 2'd1}, "R6 reused slot kept");

    // R11 invalidate and fill in the same cycle
    idle();
    inv_valid = 1'b1; inv_vpn = va(4, 0);
    fill_valid = 1'b1; fill_tag = tg(12); fill_base = bs(1); fill_mask = 4'b1111;
    #1;
    chk("R11 ready low", 64'(fill_ready), 64'(0));
    step(1'b0);
    look(va(12, 0), 1'b1 ^ 1'b1, '0, "R11 fill held off");
    look(va(4, 0), 1'b0, '0, "R9 page removed");
    look(va(4, 1), 1'b1, {bs(0), 2'd1}, "R9 neighbour kept");

    // R12 duplicate tag check: refill then drop whole group
    fill(6, 3, 4'b0001);
    inval(va(6, 0), 1'b1);
    look(va(6, 2), 1'b0, '0, "R12 single copy of tag");

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      r = int'($urandom % 10);
      lk_vpn = va(int'($urandom % 14), int'($urandom % 4));
      if (r < 5 || r == 9) begin
        fill_valid = 1'b1; fill_tag = tg(int'($urandom % 14));
        fill_base = bs(int'($urandom % 3)); fill_mask = 4'($urandom);
      end
      if (r >= 6) begin
        inv_valid = 1'b1; inv_all = ($urandom % 3) == 0;
        inv_vpn = va(int'($urandom % 14), int'($urandom % 4));
      end
      step(1'b1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule